// File: doc/BRIEF.md
# Interval Timer Command and Readback Port

This block is the byte-wide register front end of a three-channel interval timer. A host bus reaches it through four byte addresses: addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2, and address 3 is the command port. Command bytes set up each channel and can freeze counts or status. Data port writes build 16-bit counts from bytes. Data port reads return bytes of a live count, a frozen count or a status snapshot.

Each channel keeps three settings: its byte access scheme, its counting mode and its BCD flag. When a count is complete, the block sends the channel a one-cycle load strobe with the 16-bit value. When a channel is programmed, it sends a one-cycle configuration strobe. The counters themselves sit outside this block. They supply their live counts, output pin levels and count-loaded flags, and the block reports these values back to the host.

A command byte splits into three fields: bits 7-6 select the channel or a special command, bits 5-4 give the access operation, bits 3-1 give the counting mode and bit 0 gives the BCD flag. Reads return data in the same cycle as `rd_en`, through combinational logic. The side effects of a read or a write, such as advancing the byte order or releasing a latch, take effect at the clock edge that ends that cycle.

Top module: `tmr_cmd_port`

## Requirements
- R1: After reset, every channel uses 16-bit access, counting mode 0 and binary counting, and no strobes are active. The first data read after reset returns the low byte of the live count.
- R2: In 16-bit access (operation field 11), the first data write only stores a byte. The second data write makes that channel's `load_stb` pulse for one cycle, starting one clock after the write. `load_val` is {second byte, first byte} during the pulse.
- R3: In low-only access (operation field 01), each data write loads {8'h00, byte}, and data reads return the low byte. In high-only access (operation field 10), each data write loads {byte, 8'h00}, and data reads return the high byte.
- R4: A command with operation field 01, 10 or 11 sets the selected channel's access, mode and BCD flag, and leaves the other channels unchanged. The new mode and BCD flag appear on `cfg_mode` and `cfg_bcd` one clock later. The command also clears that channel's read and write byte order and its pending latches. A command of this kind whose mode field is 110 or 111 has no effect.
- R5: A command with operation field 00 freezes the selected channel's count, and the mode bits are not used. Reads then return bytes of the frozen value, even if the live count changes. The freeze ends once the value has been fully read: one byte in the single-byte schemes, two bytes in 16-bit access.
- R6: A second count freeze on a channel before its frozen value has been read has no effect.
- R7: Command nibble 1101 freezes the count of each channel whose select bit is set. Bit 3 selects channel 2, bit 2 selects channel 1 and bit 1 selects channel 0.
- R8: Command nibble 1110 captures a status byte for each selected channel, using the same select bits. The status byte is: bit 7 the output pin, bit 6 the count-loaded flag, bits 5-4 the access code, bits 3-1 the mode and bit 0 the BCD flag. In the access code, 01 means high-only, 10 means low-only and 11 means 16-bit.
- R9: If a channel has both a captured status and a frozen count, the next read returns the status byte. The reads after that return the count.
- R10: In 16-bit access, reads alternate between the low byte and the high byte, starting with the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write this cycle |
| rd_en | input | 1 | Byte read this cycle (never in the same cycle as wr_en) |
| addr | input | 2 | Port select: 0 to 2 are data ports, 3 is the command port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte (0xFF when address 3 is read) |
| cnt_live | input | 48 | Live counts of the channels, channel i in bits 16i+15:16i |
| ch_out | input | 3 | Output pin level of each channel |
| ch_loaded | input | 3 | Count-loaded flag of each channel |
| load_stb | output | 3 | One-cycle count load strobe for each channel |
| load_val | output | 48 | Count to load, channel i in bits 16i+15:16i |
| cfg_stb | output | 3 | One-cycle strobe when a channel is reprogrammed |
| cfg_mode | output | 9 | Counting mode of each channel, channel i in bits 3i+2:3i |
| cfg_bcd | output | 3 | BCD flag of each channel |

## Verification
Read data is combinational, so the bench samples `rdata` shortly after it drives `rd_en` and the address, before the edge that applies the read's side effects. Load and configuration strobes are registered: they rise one clock after the write. The bench samples them at the next falling edge, which falls inside the one-cycle pulse. Freezes and status captures take effect at the edge of their command, so the bench changes the live counts only after that edge. Any later read then shows whether the frozen value was kept.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH    = 3;
  localparam int BW     = 8;
  localparam int CW     = 2 * BW;
  localparam int ADDR_W = 2;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } acc_e;

  // Access code as reported in the status byte (high-only and low-only swap)
  function automatic logic [1:0] acc_to_rw(acc_e a);
    case (a)
      ACC_LO:   return 2'b10;
      ACC_HI:   return 2'b01;
      ACC_WORD: return 2'b11;
      default:  return 2'b00;
    endcase
  endfunction

  function automatic logic [BW-1:0] pack_status(logic pin, logic loaded, acc_e a,
                                                logic [MODE_W-1:0] mode, logic bcd);
    return {pin, loaded, acc_to_rw(a), mode, bcd};
  endfunction
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tmr_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BW-1:0]        wdata,
  output logic [N-1:0]         prog,
  output logic [N-1:0]         latch_cnt,
  output logic [N-1:0]         latch_sts,
  output logic [N-1:0]         dwr,
  output logic [N-1:0]         drd,
  output acc_e                 new_acc,
  output logic [MODE_W-1:0]    new_mode,
  output logic                 new_bcd
);
  localparam logic [3:0] NIB_RB_CNT = 4'b1101;
  localparam logic [3:0] NIB_RB_STS = 4'b1110;

  logic       is_cmd;
  logic [1:0] sel;
  logic       mode_ok;

  assign is_cmd   = wr_en && (addr == ADDR_W'(N));
  assign sel      = wdata[7:6];
  assign new_acc  = acc_e'(wdata[5:4]);
  assign new_mode = wdata[3:1];
  assign new_bcd  = wdata[0];
  assign mode_ok  = (wdata[3:2] != 2'b11);

  for (genvar i = 0; i < N; i++) begin : g_ch
    logic hit;
    assign hit          = is_cmd && (sel == 2'(i));
    assign prog[i]      = hit && (new_acc != ACC_LATCH) && mode_ok;
    assign latch_cnt[i] = (hit && new_acc == ACC_LATCH) ||
                          (is_cmd && wdata[7:4] == NIB_RB_CNT && wdata[i+1]);
    assign latch_sts[i] = is_cmd && wdata[7:4] == NIB_RB_STS && wdata[i+1];
    assign dwr[i]       = wr_en && (addr == ADDR_W'(i));
    assign drd[i]       = rd_en && (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog,
  input  acc_e              new_acc,
  input  logic [MODE_W-1:0] new_mode,
  input  logic              new_bcd,
  input  logic              latch_cnt,
  input  logic              latch_sts,
  input  logic              dwr,
  input  logic              drd,
  input  logic [BW-1:0]     wdata,
  input  logic [CW-1:0]     live,
  input  logic              pin_out,
  input  logic              loaded,
  output logic [BW-1:0]     rbyte,
  output logic              load_stb,
  output logic [CW-1:0]     load_val,
  output logic              cfg_stb,
  output logic [MODE_W-1:0] mode,
  output logic              bcd,
  output acc_e              acc
);
  logic          wr_hi, rd_hi;
  logic [BW-1:0] lo_hold;
  logic [CW-1:0] cnt_lat;
  logic          cnt_v;
  logic [BW-1:0] sts_lat;
  logic          sts_v;

  function automatic logic [BW-1:0] pick_byte(logic [CW-1:0] v, acc_e a, logic hi_next);
    if (a == ACC_HI || (a == ACC_WORD && hi_next)) return v[CW-1:BW];
    return v[BW-1:0];
  endfunction

  assign rbyte = sts_v ? sts_lat : pick_byte(cnt_v ? cnt_lat : live, acc, rd_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= ACC_WORD;
      mode     <= '0;
      bcd      <= 1'b0;
      wr_hi    <= 1'b0;
      rd_hi    <= 1'b0;
      lo_hold  <= '0;
      cnt_lat  <= '0;
      cnt_v    <= 1'b0;
      sts_lat  <= '0;
      sts_v    <= 1'b0;
      load_stb <= 1'b0;
      load_val <= '0;
      cfg_stb  <= 1'b0;
    end else begin
      load_stb <= 1'b0;
      cfg_stb  <= 1'b0;
      if (prog) begin
        acc     <= new_acc;
        mode    <= new_mode;
        bcd     <= new_bcd;
        wr_hi   <= 1'b0;
        rd_hi   <= 1'b0;
        cnt_v   <= 1'b0;
        sts_v   <= 1'b0;
        cfg_stb <= 1'b1;
      end
      if (latch_cnt && !cnt_v) begin
        cnt_lat <= live;
        cnt_v   <= 1'b1;
      end
      if (latch_sts && !sts_v) begin
        sts_lat <= pack_status(pin_out, loaded, acc, mode, bcd);
        sts_v   <= 1'b1;
      end
      if (dwr) begin
        case (acc)
          ACC_LO: begin
            load_stb <= 1'b1;
            load_val <= {{BW{1'b0}}, wdata};
          end
          ACC_HI: begin
            load_stb <= 1'b1;
            load_val <= {wdata, {BW{1'b0}}};
          end
          ACC_WORD: begin
            if (!wr_hi) begin
              lo_hold <= wdata;
              wr_hi   <= 1'b1;
            end else begin
              load_stb <= 1'b1;
              load_val <= {wdata, lo_hold};
              wr_hi    <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (drd) begin
        if (sts_v) begin
          sts_v <= 1'b0;
        end else if (acc == ACC_WORD && !rd_hi) begin
          rd_hi <= 1'b1;
        end else begin
          rd_hi <= 1'b0;
          cnt_v <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_cmd_port.sv
module tmr_cmd_port
  import tmr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BW-1:0]            wdata,
  output logic [BW-1:0]            rdata,
  input  logic [NCH*CW-1:0]        cnt_live,
  input  logic [NCH-1:0]           ch_out,
  input  logic [NCH-1:0]           ch_loaded,
  output logic [NCH-1:0]           load_stb,
  output logic [NCH*CW-1:0]        load_val,
  output logic [NCH-1:0]           cfg_stb,
  output logic [NCH*MODE_W-1:0]    cfg_mode,
  output logic [NCH-1:0]           cfg_bcd
);
  logic [NCH-1:0]    prog, latch_cnt, latch_sts, dwr, drd;
  acc_e              new_acc;
  logic [MODE_W-1:0] new_mode;
  logic              new_bcd;
  logic [BW-1:0]     rbyte [NCH];
  logic [2*NCH-1:0]  acc_q;

  tmr_cmd_decode #(.N(NCH)) dec_i (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .prog(prog), .latch_cnt(latch_cnt), .latch_sts(latch_sts),
    .dwr(dwr), .drd(drd),
    .new_acc(new_acc), .new_mode(new_mode), .new_bcd(new_bcd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    acc_e acc_i;
    tmr_chan_port ch_i (
      .clk(clk), .rst_n(rst_n),
      .prog(prog[i]), .new_acc(new_acc), .new_mode(new_mode), .new_bcd(new_bcd),
      .latch_cnt(latch_cnt[i]), .latch_sts(latch_sts[i]),
      .dwr(dwr[i]), .drd(drd[i]), .wdata(wdata),
      .live(cnt_live[i*CW +: CW]), .pin_out(ch_out[i]), .loaded(ch_loaded[i]),
      .rbyte(rbyte[i]),
      .load_stb(load_stb[i]), .load_val(load_val[i*CW +: CW]),
      .cfg_stb(cfg_stb[i]),
      .mode(cfg_mode[i*MODE_W +: MODE_W]), .bcd(cfg_bcd[i]),
      .acc(acc_i)
    );
    assign acc_q[2*i +: 2] = acc_i;
  end

  always_comb begin
    rdata = '1;
    for (int i = 0; i < NCH; i++)
      if (addr == ADDR_W'(i)) rdata = rbyte[i];
  end
endmodule

// File: rtl/tmr_cmd_port_chk.sv
module tmr_cmd_port_chk
  import tmr_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [BW-1:0]         wdata,
  input logic [NCH-1:0]        load_stb,
  input logic [NCH*CW-1:0]     load_val,
  input logic [NCH-1:0]        cfg_stb,
  input logic [2*NCH-1:0]      acc_q
);
  // R2: one shared bus, so at most one channel loads per cycle
  a_r2_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_stb));

  // R4: a reprogram strobe is always due to a command port write
  a_r4_cfg_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (|cfg_stb) |-> $past(wr_en && addr == ADDR_W'(NCH)));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R2: a load strobe follows a write to that channel's data port
    a_r2_load_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb[i] |-> $past(wr_en && addr == ADDR_W'(i)));
    // R3: low-only loads clear the high byte and carry the written byte
    a_r3_lo_only_value: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb[i] && acc_q[2*i +: 2] == ACC_LO) |->
        (load_val[i*CW+BW +: BW] == '0 && load_val[i*CW +: BW] == $past(wdata)));
    // R3: high-only loads clear the low byte
    a_r3_hi_only_value: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb[i] && acc_q[2*i +: 2] == ACC_HI) |->
        (load_val[i*CW +: BW] == '0 && load_val[i*CW+BW +: BW] == $past(wdata)));
  end
endmodule

bind tmr_cmd_port tmr_cmd_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .load_stb(load_stb), .load_val(load_val), .cfg_stb(cfg_stb), .acc_q(acc_q)
);

// File: tb/tmr_cmd_port_tb.sv
`timescale 1ns/1ps
module tmr_cmd_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [1:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [15:0] live [3];
  logic [47:0] cnt_live;
  logic [2:0]  ch_out, ch_loaded;
  logic [2:0]  load_stb, cfg_stb, cfg_bcd;
  logic [47:0] load_val;
  logic [8:0]  cfg_mode;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;
  assign cnt_live = {live[2], live[1], live[0]};

  tmr_cmd_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cnt_live(cnt_live), .ch_out(ch_out),
    .ch_loaded(ch_loaded), .load_stb(load_stb), .load_val(load_val),
    .cfg_stb(cfg_stb), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Write; returns the strobes and the channel's load value at the next falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d,
                    output logic [2:0] ld, output logic [15:0] lv);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
    @(negedge clk); ld = load_stb; lv = load_val[(a%3)*16 +: 16];
  endtask

  task automatic cmd(input logic [7:0] d);
    logic [2:0] ld; logic [15:0] lv;
    wr(2'd3, d, ld, lv);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] q);
    @(negedge clk); rd_en = 1'b1; addr = a; #2 q = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] q;
    check("R1 load_stb idle", load_stb, 0);
    check("R1 cfg_mode", cfg_mode, 0);
    check("R1 cfg_bcd", cfg_bcd, 0);
    live[0] = 16'h1234;
    rd(2'd0, q); check("R1 first read low byte", q, 8'h34);
    rd(2'd0, q); check("R10 second read high byte", q, 8'h12);
  endtask

  task automatic t_word_write();
    logic [2:0] ld; logic [15:0] lv;
    cmd(8'h34);                                   // ch0, 16-bit, mode 2
    check("R4 ch0 mode set", cfg_mode[2:0], 2);
    wr(2'd0, 8'h10, ld, lv); check("R2 no load after first byte", ld, 0);
    wr(2'd0, 8'h27, ld, lv);
    check("R2 load strobe ch0", ld, 3'b001);
    check("R2 load value", lv, 16'h2710);
  endtask

  task automatic t_byte_modes();
    logic [2:0] ld; logic [15:0] lv; logic [7:0] q;
    cmd(8'h50);                                   // ch1 low-only, mode 0
    wr(2'd1, 8'hAB, ld, lv);
    check("R3 lo-only strobe", ld, 3'b010);
    check("R3 lo-only value", lv, 16'h00AB);
    live[1] = 16'h5678;
    rd(2'd1, q); check("R3 lo-only read", q, 8'h78);
    rd(2'd1, q); check("R3 lo-only read again", q, 8'h78);
    cmd(8'h60);                                   // ch1 high-only
    wr(2'd1, 8'hCD, ld, lv);
    check("R3 hi-only value", lv, 16'hCD00);
    rd(2'd1, q); check("R3 hi-only read", q, 8'h56);
  endtask

  task automatic t_undefined_mode();
    cmd(8'hBD);                                   // ch2 mode 110: ignored
    check("R4 undefined mode ignored", cfg_mode[8:6], 0);
    check("R4 undefined bcd ignored", cfg_bcd[2], 0);
    cmd(8'hB7);                                   // ch2 16-bit mode 3 BCD
    check("R4 ch2 mode", cfg_mode[8:6], 3);
    check("R4 ch2 bcd", cfg_bcd[2], 1);
    check("R4 ch0 untouched", cfg_mode[2:0], 2);
  endtask

  task automatic t_reprogram_order();
    logic [2:0] ld; logic [15:0] lv; logic [7:0] q;
    live[2] = 16'hBEEF;
    rd(2'd2, q); check("R10 ch2 low first", q, 8'hEF);
    cmd(8'hB7);
    rd(2'd2, q); check("R10 read order reset by program", q, 8'hEF);
    rd(2'd2, q); check("R10 then high", q, 8'hBE);
    wr(2'd2, 8'h11, ld, lv);
    cmd(8'hB7);
    wr(2'd2, 8'h22, ld, lv); check("R4 write order reset", ld, 0);
    wr(2'd2, 8'h33, ld, lv);
    check("R4 load after reprogram", lv, 16'h3322);
  endtask

  task automatic t_latch();
    logic [7:0] q;
    live[0] = 16'h1111; cmd(8'h00);
    live[0] = 16'h2222; cmd(8'h0E);               // mode bits ignored; repeat ignored
    rd(2'd0, q); check("R6 first latch kept lo", q, 8'h11);
    live[0] = 16'h3333;
    rd(2'd0, q); check("R5 frozen high byte", q, 8'h11);
    rd(2'd0, q); check("R5 freeze released", q, 8'h33);
    rd(2'd0, q);
  endtask

  task automatic t_readback_cnt();
    logic [7:0] q;
    live[0] = 16'hA0A1; live[1] = 16'hB0B1; live[2] = 16'hC0C1;
    cmd(8'hDA);                                   // 1101, bits 3 and 1: ch2, ch0
    live[0] = 16'h0000; live[1] = 16'h0102; live[2] = 16'h0000;
    rd(2'd0, q); check("R7 ch0 frozen lo", q, 8'hA1);
    rd(2'd0, q); check("R7 ch0 frozen hi", q, 8'hA0);
    rd(2'd1, q); check("R7 ch1 not selected", q, 8'h01);
    rd(2'd2, q); check("R7 ch2 frozen lo", q, 8'hC1);
    rd(2'd2, q); check("R7 ch2 frozen hi", q, 8'hC0);
  endtask

  task automatic t_status();
    logic [7:0] q;
    ch_out = 3'b010; ch_loaded = 3'b011;
    live[1] = 16'h4455; cmd(8'h40);               // freeze ch1
    cmd(8'hE4);                                   // status ch1
    live[1] = 16'h9999;
    rd(2'd1, q); check("R9 status first", q, 8'hD0);
    rd(2'd1, q); check("R9 then frozen count", q, 8'h44);
    rd(2'd1, q); check("R5 released to live", q, 8'h99);
    cmd(8'hE8);
    rd(2'd2, q); check("R8 ch2 status 16-bit bcd", q, 8'h37);
    cmd(8'h12);                                   // ch0 low-only mode 1
    cmd(8'hE2);
    rd(2'd0, q); check("R8 ch0 status low-only code", q, 8'h62);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    ch_out = '0; ch_loaded = '0;
    for (int i = 0; i < 3; i++) live[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_write();
    t_byte_modes();
    t_undefined_mode();
    t_reprogram_order();
    t_latch();
    t_readback_cnt();
    t_status();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule